// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a dot-product engine for signed fractional data, such as a FIR filter tap loop. It can take one sample and one coefficient on every clock. It multiplies them at full precision and adds the product into a wide accumulator. The accumulator has guard bits above the product width, so long sums can run past the operand range without wrapping.

A separate store command turns the current accumulator value back into a data-width word. The store first applies a signed arithmetic scaling shift. It then either truncates or rounds to nearest, and clamps any result outside the word range to the largest or smallest code. A sticky flag records that clamping happened. Fetching operands, storing coefficients and sequencing the filter are left to the surrounding logic.

Top module: `fxp_mac_sat`

## Requirements
- R1: While reset is high, the accumulator, `out_word`, `out_valid` and `sat_flag` all go to zero. A store issued straight after reset yields 16'h0000.
- R2: Operands are signed two's-complement fractions with DW-1 fraction bits (default Q1.15). Their full 2*DW-bit product is accumulated with 2*(DW-1) fraction bits. Example: a store with shift 0 in truncate mode of 16384*16384 gives 16'h2000.
- R3: A cycle with `in_valid` high and `acc_clear` low adds the product to the accumulator at that clock edge. A cycle with both low leaves the accumulator unchanged, whatever the operand values.
- R4: With `acc_clear` high, the accumulator is loaded with the current product if `in_valid` is high, or set to zero if `in_valid` is low. The old value is discarded in both cases.
- R5: The accumulator carries GW guard bits (default 8) above the 2*DW product width. Intermediate sums up to 2^(GW-1) times full scale are kept exactly and can be scaled back into range.
- R6: With `round_mode` = 0 (truncate), the DW-1 low fraction bits of the scaled value are dropped. This rounds toward minus infinity.
- R7: With `round_mode` = 1 (nearest), half an output LSB is added before the low bits are dropped, so exact halves round upward.
- R8: A scaled result above 0.99997 stores 16'h7FFF, and a result below -1.0 stores 16'h8000. A result never wraps to the opposite sign.
- R9: If rounding carries a value past the most positive code, the store saturates to 16'h7FFF. Truncating the same value does not saturate.
- R10: `shift_amt` is a two's-complement count from -2^(SHW-1) to 2^(SHW-1)-1. A positive count is an arithmetic left shift and a negative count is an arithmetic right shift. The shift is applied before rounding and saturation.
- R11: `sat_flag` is set by every store that saturates and then stays set. It is cleared by `flag_clr` only. If a saturating store and `flag_clr` arrive in the same cycle, the flag is set.
- R12: `out_word` takes the stored value at the clock edge that samples `store_req`, and holds it until the next store. `out_valid` is high for exactly the one cycle after each store request. A store reads the accumulator value from before any accumulation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair valid |
| in_sample | input | DW | Signed data sample |
| in_coef | input | DW | Signed coefficient |
| acc_clear | input | 1 | Restart the accumulator (load product or zero) |
| store_req | input | 1 | Reduce the accumulator into the output register |
| round_mode | input | 1 | 0 truncate, 1 round to nearest |
| shift_amt | input | SHW | Signed scaling shift, positive means left |
| flag_clr | input | 1 | Clear the sticky saturation flag |
| out_word | output | DW | Stored, scaled, saturated result |
| out_valid | output | 1 | One-cycle strobe after each store |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
An accepted operand pair changes the accumulator at the same rising edge that samples it. A store request shows up on `out_word`, `out_valid` and `sat_flag` at the next rising edge, which makes the store result due exactly one edge after the request. The bench drives every input on a falling edge and reads the outputs on the following falling edge. Each check therefore lands half a cycle after the edge that produced it and before any later stimulus takes effect. Sequences that build up several products insert one cycle per pair and issue the store in a separate cycle, except for the one test that deliberately overlaps a store with an accumulation.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

    localparam int DATA_W_DEF  = 16;
    localparam int GUARD_W_DEF = 8;
    localparam int SHIFT_W_DEF = 4;

    typedef enum logic {
        RND_TRUNC   = 1'b0,
        RND_NEAREST = 1'b1
    } rnd_mode_e;

    typedef struct packed {
        logic      store;
        rnd_mode_e mode;
    } store_ctl_t;

    // largest left shift a signed count of the given width can request
    function automatic int shift_reach(input int shw);
        return (2 ** (shw - 1)) - 1;
    endfunction

endpackage

// File: rtl/fxp_mac_mul.sv
module fxp_mac_mul #(
    parameter int DW = fxp_mac_pkg::DATA_W_DEF
) (
    input  logic signed [DW-1:0]   op_a,
    input  logic signed [DW-1:0]   op_b,
    output logic signed [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    // both operands sign-extended to the product width, no bits dropped
    always_comb begin
        prod = PW'(op_a) * PW'(op_b);
    end
endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc #(
    parameter int DW = fxp_mac_pkg::DATA_W_DEF,
    parameter int GW = fxp_mac_pkg::GUARD_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       take,
    input  logic                       restart,
    input  logic signed [2*DW-1:0]     prod,
    output logic signed [2*DW+GW-1:0]  acc
);
    localparam int PW = 2 * DW;
    localparam int AW = PW + GW;

    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] addend_base;

    always_comb begin
        prod_ext    = {{GW{prod[PW-1]}}, prod};
        addend_base = restart ? '0 : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (take) begin
            acc <= addend_base + prod_ext;
        end else if (restart) begin
            acc <= '0;
        end
    end
endmodule

// File: rtl/fxp_mac_reduce.sv
module fxp_mac_reduce
    import fxp_mac_pkg::*;
#(
    parameter int DW  = DATA_W_DEF,
    parameter int GW  = GUARD_W_DEF,
    parameter int SHW = SHIFT_W_DEF
) (
    input  logic signed [2*DW+GW-1:0] acc,
    input  rnd_mode_e                 mode,
    input  logic signed [SHW-1:0]     shift_amt,
    output logic        [DW-1:0]      word,
    output logic                      sat
);
    localparam int AW    = 2 * DW + GW;
    localparam int REACH = shift_reach(SHW);
    localparam int SW    = AW + REACH + 1;
    localparam int DROP  = DW - 1;

    localparam logic signed [SW-1:0] HALF  = SW'(1) <<< (DROP - 1);
    localparam logic signed [SW-1:0] MAXV  = (SW'(1) <<< (DW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] MINV  = -MAXV - SW'(1);
    localparam logic        [DW-1:0] CODE_HI = {1'b0, {(DW-1){1'b1}}};
    localparam logic        [DW-1:0] CODE_LO = {1'b1, {(DW-1){1'b0}}};

    logic signed [SW-1:0]  wide;
    logic signed [SW-1:0]  scaled;
    logic signed [SW-1:0]  biased;
    logic signed [SW-1:0]  quot;
    logic        [SHW-1:0] right_cnt;
    logic                  too_big;
    logic                  too_small;

    always_comb begin
        wide      = {{(SW-AW){acc[AW-1]}}, acc};
        right_cnt = ~shift_amt + SHW'(1);
        if (shift_amt[SHW-1]) begin
            scaled = wide >>> right_cnt;
        end else begin
            scaled = wide <<< shift_amt;
        end
    end

    generate
        if (DROP > 0) begin : g_drop
            always_comb begin
                biased = (mode == RND_NEAREST) ? scaled + HALF : scaled;
                quot   = biased >>> DROP;
            end
        end else begin : g_keep
            always_comb begin
                biased = scaled;
                quot   = biased;
            end
        end
    endgenerate

    always_comb begin
        too_big   = (quot > MAXV);
        too_small = (quot < MINV);
        sat       = too_big | too_small;
        if (too_big) begin
            word = CODE_HI;
        end else if (too_small) begin
            word = CODE_LO;
        end else begin
            word = quot[DW-1:0];
        end
    end
endmodule

// File: rtl/fxp_mac_sat.sv
module fxp_mac_sat
    import fxp_mac_pkg::*;
#(
    parameter int DW  = DATA_W_DEF,
    parameter int GW  = GUARD_W_DEF,
    parameter int SHW = SHIFT_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [DW-1:0]  in_sample,
    input  logic signed [DW-1:0]  in_coef,
    input  logic                  acc_clear,
    input  logic                  store_req,
    input  logic                  round_mode,
    input  logic signed [SHW-1:0] shift_amt,
    input  logic                  flag_clr,
    output logic        [DW-1:0]  out_word,
    output logic                  out_valid,
    output logic                  sat_flag
);
    localparam int PW = 2 * DW;
    localparam int AW = PW + GW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc;
    logic        [DW-1:0] red_word;
    logic                 red_sat;
    store_ctl_t           ctl;

    always_comb begin
        ctl.store = store_req;
        ctl.mode  = rnd_mode_e'(round_mode);
    end

    fxp_mac_mul #(.DW(DW)) u_mul (
        .op_a (in_sample),
        .op_b (in_coef),
        .prod (prod)
    );

    fxp_mac_acc #(.DW(DW), .GW(GW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .restart (acc_clear),
        .prod    (prod),
        .acc     (acc)
    );

    fxp_mac_reduce #(.DW(DW), .GW(GW), .SHW(SHW)) u_red (
        .acc       (acc),
        .mode      (ctl.mode),
        .shift_amt (shift_amt),
        .word      (red_word),
        .sat       (red_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            out_valid <= 1'b0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= ctl.store;
            if (ctl.store) begin
                out_word <= red_word;
            end
            sat_flag <= (ctl.store & red_sat) | (sat_flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/fxp_mac_sat_chk.sv
module fxp_mac_sat_chk #(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  acc_clear,
    input logic                  store_req,
    input logic                  flag_clr,
    input logic                  red_sat,
    input logic [2*DW+GW-1:0]    acc,
    input logic [DW-1:0]         out_word,
    input logic                  out_valid,
    input logic                  sat_flag
);
    localparam logic [DW-1:0] CODE_HI = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] CODE_LO = {1'b1, {(DW-1){1'b0}}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (acc == '0 && out_word == '0 && !out_valid && !sat_flag)); // R1

    AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !acc_clear) |=> $stable(acc)); // R3

    AST_STROBE_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        store_req |=> out_valid); // R12

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !store_req |=> !out_valid); // R12

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !store_req |=> $stable(out_word)); // R12

    AST_SAT_CODE: assert property (@(posedge clk) disable iff (rst)
        (store_req && red_sat) |=> (out_word == CODE_HI || out_word == CODE_LO)); // R8

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (store_req && red_sat) |=> sat_flag); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !flag_clr) |=> sat_flag); // R11

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !store_req) |=> !sat_flag); // R11
endmodule

bind fxp_mac_sat fxp_mac_sat_chk #(.DW(DW), .GW(GW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .acc_clear (acc_clear),
    .store_req (store_req),
    .flag_clr  (flag_clr),
    .red_sat   (red_sat),
    .acc       (acc),
    .out_word  (out_word),
    .out_valid (out_valid),
    .sat_flag  (sat_flag)
);

// File: tb/sim_fxp_mac_sat.sv
module sim_fxp_mac_sat;
    localparam int DW  = 16;
    localparam int SHW = 4;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic signed [DW-1:0]  in_sample = '0;
    logic signed [DW-1:0]  in_coef = '0;
    logic                  acc_clear = 1'b0;
    logic                  store_req = 1'b0;
    logic                  round_mode = 1'b0;
    logic signed [SHW-1:0] shift_amt = '0;
    logic                  flag_clr = 1'b0;
    logic [DW-1:0]         out_word;
    logic                  out_valid;
    logic                  sat_flag;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    fxp_mac_sat #(.DW(DW), .GW(8), .SHW(SHW)) u0 (
        .clk, .rst, .in_valid, .in_sample, .in_coef, .acc_clear,
        .store_req, .round_mode, .shift_amt, .flag_clr,
        .out_word, .out_valid, .sat_flag
    );

    typedef struct packed {
        logic [23:0]          tag;
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
        logic                 rnd;
        logic [SHW-1:0]       sh;
        logic [DW-1:0]        exp_word;
        logic                 exp_sat;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{"R2 ",  16'sd16384,  16'sd16384, 1'b0, 4'h0, 16'h2000, 1'b0},
        '{"R4 ", -16'sd16384,  16'sd16384, 1'b0, 4'h0, 16'hE000, 1'b0},
        '{"R6 ",  16'sd1,      16'sd16384, 1'b0, 4'h0, 16'h0000, 1'b0},
        '{"R7 ",  16'sd1,      16'sd16384, 1'b1, 4'h0, 16'h0001, 1'b0},
        '{"R6 ", -16'sd1,      16'sd16384, 1'b0, 4'h0, 16'hFFFF, 1'b0},
        '{"R7 ", -16'sd1,      16'sd16384, 1'b1, 4'h0, 16'h0000, 1'b0},
        '{"R8 ", -16'sd32768, -16'sd32768, 1'b0, 4'h0, 16'h7FFF, 1'b1},
        '{"R10",  16'sd16384,  16'sd16384, 1'b0, 4'h2, 16'h7FFF, 1'b1},
        '{"R10",  16'sd16384,  16'sd16384, 1'b0, 4'hE, 16'h0800, 1'b0},
        '{"R2 ", -16'sd32768,  16'sd32767, 1'b0, 4'h0, 16'h8001, 1'b0},
        '{"R8 ", -16'sd32768,  16'sd32767, 1'b0, 4'h1, 16'h8000, 1'b1},
        '{"R10",  16'sd12345, -16'sd2,     1'b0, 4'h3, 16'hFFF9, 1'b0},
        '{"R7 ",  16'sd12345, -16'sd2,     1'b1, 4'h3, 16'hFFFA, 1'b0},
        '{"R10",  16'sd100,    16'sd100,   1'b1, 4'h7, 16'h0027, 1'b0},
        '{"R10",  16'sd16384,  16'sd16384, 1'b0, 4'h8, 16'h0020, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        in_valid  = 1'b0;
        acc_clear = 1'b0;
        store_req = 1'b0;
        flag_clr  = 1'b0;
    endtask

    task automatic feed(input logic clr, input logic signed [DW-1:0] a,
                        input logic signed [DW-1:0] b);
        in_valid  = 1'b1;
        acc_clear = clr;
        in_sample = a;
        in_coef   = b;
        cyc();
        idle_inputs();
    endtask

    task automatic store(input logic rnd, input logic [SHW-1:0] sh);
        store_req  = 1'b1;
        round_mode = rnd;
        shift_amt  = sh;
        cyc();
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        // R1: reset state
        check("R1", "out_word after reset", out_word, 16'h0000);
        check("R1", "out_valid after reset", {15'd0, out_valid}, 16'd0);
        check("R1", "sat_flag after reset", {15'd0, sat_flag}, 16'd0);
        store(1'b0, 4'h0);
        check("R1", "store of cleared accumulator", out_word, 16'h0000);

        // table: clear-load one product, then store it
        for (int i = 0; i < NV; i++) begin
            flag_clr = 1'b1;
            feed(1'b1, VECS[i].a, VECS[i].b);
            store(VECS[i].rnd, VECS[i].sh);
            check(string'(VECS[i].tag), $sformatf("vector %0d word", i),
                  out_word, VECS[i].exp_word);
            check(string'(VECS[i].tag), $sformatf("vector %0d flag", i),
                  {15'd0, sat_flag}, {15'd0, VECS[i].exp_sat});
        end

        // R3: accumulation, with an ignored idle cycle carrying operands
        flag_clr = 1'b1;
        feed(1'b1, 16'sd16384, 16'sd16384);
        feed(1'b0, 16'sd8192, 16'sd16384);
        in_sample = 16'sd32767;
        in_coef   = 16'sd32767;
        cyc();
        feed(1'b0, 16'sd8192, 16'sd16384);
        feed(1'b0, 16'sd8192, 16'sd16384);
        store(1'b0, 4'h0);
        check("R3", "sum of four products", out_word, 16'h5000);
        check("R12", "out_valid one cycle after store", {15'd0, out_valid}, 16'd1);
        cyc();
        check("R12", "out_valid drops", {15'd0, out_valid}, 16'd0);
        check("R12", "out_word held", out_word, 16'h5000);

        // R12: store and accumulate in one cycle reads the old value
        in_valid  = 1'b1;
        in_sample = 16'sd8192;
        in_coef   = 16'sd16384;
        store(1'b0, 4'h0);
        check("R12", "store sees pre-update accumulator", out_word, 16'h5000);
        store(1'b0, 4'h0);
        check("R3", "overlapped product was added", out_word, 16'h6000);

        // R4: clear without valid zeroes the accumulator
        acc_clear = 1'b1;
        cyc();
        idle_inputs();
        store(1'b0, 4'h0);
        check("R4", "clear without valid", out_word, 16'h0000);

        // R5: guard bits keep 4.0 exactly, shift back into range
        flag_clr = 1'b1;
        feed(1'b1, -16'sd32768, -16'sd32768);
        for (int k = 0; k < 3; k++) feed(1'b0, -16'sd32768, -16'sd32768);
        store(1'b0, 4'hD);
        check("R5", "4.0 scaled by 1/8", out_word, 16'h4000);
        check("R5", "no saturation on scaled sum", {15'd0, sat_flag}, 16'd0);
        store(1'b0, 4'h0);
        check("R8", "unscaled 4.0 clamps", out_word, 16'h7FFF);

        // R9 / R11: rounding overflow and the sticky flag
        flag_clr = 1'b1;
        feed(1'b1, 16'sd32767, 16'sd32767);
        feed(1'b0, 16'sd32767, 16'sd2);
        store(1'b1, 4'h0);
        check("R9", "rounding carry saturates", out_word, 16'h7FFF);
        check("R11", "flag set by rounding overflow", {15'd0, sat_flag}, 16'd1);
        cyc();
        check("R11", "flag sticky while idle", {15'd0, sat_flag}, 16'd1);
        flag_clr = 1'b1;
        cyc();
        idle_inputs();
        check("R11", "flag cleared", {15'd0, sat_flag}, 16'd0);
        store(1'b0, 4'h0);
        check("R9", "truncate gives top code", out_word, 16'h7FFF);
        check("R9", "truncate does not saturate", {15'd0, sat_flag}, 16'd0);
        flag_clr = 1'b1;
        store(1'b1, 4'h0);
        check("R11", "set wins over clear", {15'd0, sat_flag}, 16'd1);

        done = 1'b1;
        finish_run();
    end
endmodule